// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer for a Synchronous Buck Stage

This block turns a single PWM command into the two gate enables of a synchronous buck power stage. It does not use a fixed dead time. Before it turns on the high-side switch, it waits for a comparator flag showing that the low-side gate has discharged. Before it turns on the low-side switch, it waits for a flag showing that the high-side gate-to-phase voltage has collapsed. Each of these waits is bounded by a programmable timeout. If the expected flag never arrives, the pending turn-on is abandoned and a fault is raised.

A mode input selects between two behaviours. In forced continuous conduction, the low side conducts for the whole PWM-low interval. In diode-emulation mode, a zero-cross comparator cuts the low side off before the inductor current reverses, and the low side then stays off until the next PWM falling edge. After every high-side turn-off, a programmable minimum off interval is enforced, which gives the bootstrap capacitor time to recharge. A one-cycle strobe inside that interval tells an external over-current monitor when to sample the phase node.

All asynchronous inputs pass through synchronizers of two flops. The comparators, the gate drivers and the over-current measurement are outside the block.

Top module: `adt_gate_ctrl`

## Requirements
- R1: `hs_en` and `ls_en` are never both high in any clock cycle.
- R2: While `rst` is high and right after it is released, all outputs are low. Both enables stay low until the first PWM edge is seen after reset, even if both sense flags are high.
- R3: `hs_en` may rise only if `lg_low_in` was high three clock edges earlier. With the flag already high and no minimum-off interval pending, `hs_en` rises on the 4th rising clock edge after `pwm_in` rises. It stays low for as long as the flag stays low.
- R4: `ls_en` may rise only if `ug_low_in` was high three clock edges earlier. When the flag rises late, `ls_en` follows on the 3rd rising edge after the flag.
- R5: With `fccm_in` low, when `zc_in` rises while `ls_en` is high, `ls_en` drops on the 3rd rising edge after `zc_in` rises.
- R6: After a zero-cross cut-off, `ls_en` stays low even when `zc_in` returns low. It can turn on again only after the next PWM falling edge.
- R7: With `fccm_in` high, `zc_in` has no effect. `ls_en` stays high until a PWM rising edge is seen.
- R8: After every fall of `hs_en`, `hs_en` stays low for at least `min_off_cyc` clock cycles. A PWM rising edge that arrives inside this interval delays the high-side turn-on until the interval ends.
- R9: When `min_off_cyc` ≥ 1, every high-side off interval contains exactly one single-cycle `oc_sample` pulse. The pulse falls in the `min_off_cyc`-th cycle after `hs_en` falls, and `hs_en` is low during it.
- R10: A turn-on wait ends in the fault state when its sense flag (synchronized) stays low for `sense_timeout`+1 consecutive cycles. In that state `fault` is high and both enables are low, even if the flag arrives later. The next PWM edge clears `fault` and starts a fresh turn-on wait.
- R11: A PWM edge in the opposite direction cancels a pending turn-on wait. For example, a PWM falling edge seen before the high side has turned on means `hs_en` never rises, and the low-side wait begins instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM command; high asks for the high side |
| fccm_in | input | 1 | Asynchronous mode select; high forces continuous conduction |
| zc_in | input | 1 | Asynchronous zero-cross comparator; high means the inductor current is about to reverse |
| lg_low_in | input | 1 | Asynchronous flag; high means the low-side gate is below its threshold |
| ug_low_in | input | 1 | Asynchronous flag; high means the high-side gate-to-phase voltage is below its threshold |
| min_off_cyc | input | CNT_W | Minimum high-side off time in clock cycles |
| sense_timeout | input | CNT_W | Longest wait for a sense flag, in cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| oc_sample | output | 1 | One-cycle strobe for the over-current monitor |
| fault | output | 1 | A sense-flag wait timed out |

## Verification
Directed sequences drive PWM edges while each sense flag is held, late or missing. These show whether a turn-on is gated by the correct flag, whether it happens at the expected edge, and whether a missing flag ends in the fault state rather than a late turn-on. Zero-cross pulses are applied in both modes. They separate an immediate cut-off that is held until the next PWM fall from a stage that ignores the comparator entirely. Short PWM-low gaps shorter than the minimum off interval show whether the high-side turn-on is deferred and where the sample strobe lands. A long random run then drives PWM periods, flag glitches, zero-cross events and mode changes from a fixed seed. That run checks every transition against bench-computed expectations derived from the synchronizer latency.

// File: rtl/adt_pkg.sv
package adt_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HS_WAIT,
        ST_HS_ON,
        ST_LS_WAIT,
        ST_LS_ON,
        ST_LS_HOLD,
        ST_FAULT
    } seq_st_e;

    // Asynchronous sense inputs, carried together through the synchronizer
    typedef struct packed {
        logic pwm;
        logic fccm;
        logic zc;
        logic lg_low;
        logic ug_low;
    } sense_t;

    localparam int SENSE_W = $bits(sense_t);

    // Registered drive word
    typedef struct packed {
        logic hs;
        logic ls;
        logic flt;
    } drive_t;

    function automatic drive_t drive_of(input seq_st_e s);
        drive_t d;
        d     = '0;
        d.hs  = (s == ST_HS_ON);
        d.ls  = (s == ST_LS_ON);
        d.flt = (s == ST_FAULT);
        return d;
    endfunction

    function automatic logic is_wait(input seq_st_e s);
        return (s == ST_HS_WAIT) || (s == ST_LS_WAIT);
    endfunction

endpackage

// File: rtl/adt_sync.sv
module adt_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/adt_offtimer.sv
module adt_offtimer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_drop,
    input  logic             hs_en,
    input  logic [CNT_W-1:0] min_off,
    output logic             busy,
    output logic             oc_sample
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (hs_drop)        remain <= min_off;
        else if (remain != '0)   remain <= remain - ONE;
    end

    // Turn-on may happen at the edge that ends the last off cycle
    assign busy      = remain > ONE;
    assign oc_sample = remain == ONE;

    // Checker state: length of the current high-side low run
    logic [CNT_W:0]   low_run;
    logic [CNT_W-1:0] lim_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            lim_lat <= '0;
        end else if (hs_drop) begin
            low_run <= (CNT_W+1)'(1);
            lim_lat <= min_off;
        end else if (!hs_en && (low_run != '1)) begin
            low_run <= low_run + (CNT_W+1)'(1);
        end
    end

    AST_MIN_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> ($past(low_run) >= {1'b0, $past(lim_lat)}))
        else $error("high side reasserted before minimum off"); // R8
    AST_OC_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        oc_sample |-> !hs_en)
        else $error("sample strobe while high side on"); // R9
    AST_OC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        oc_sample |=> !oc_sample)
        else $error("sample strobe longer than one cycle"); // R9

endmodule

// File: rtl/adt_seq.sv
module adt_seq
    import adt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sense_t           sn,
    input  logic             moff_busy,
    input  logic [CNT_W-1:0] timeout,
    output logic             hs_en,
    output logic             ls_en,
    output logic             fault,
    output logic             hs_drop
);

    seq_st_e          st, nx;
    drive_t           drv_q, drv_nx;
    logic             pwm_d;
    logic             rise, fall;
    logic             flag_ok, expired;
    logic [CNT_W-1:0] wcnt, wcnt_nx;

    assign rise = sn.pwm & ~pwm_d;
    assign fall = ~sn.pwm & pwm_d;

    always_comb begin
        case (st)
            ST_HS_WAIT: flag_ok = sn.lg_low;
            ST_LS_WAIT: flag_ok = sn.ug_low;
            default:    flag_ok = 1'b1;
        endcase
    end

    assign expired = !flag_ok && (wcnt >= timeout);

    always_comb begin
        nx = st;
        case (st)
            ST_IDLE, ST_FAULT: begin
                if (rise)      nx = ST_HS_WAIT;
                else if (fall) nx = ST_LS_WAIT;
            end
            ST_HS_WAIT: begin
                if (fall)                          nx = ST_LS_WAIT;
                else if (sn.lg_low && !moff_busy)  nx = ST_HS_ON;
                else if (expired)                  nx = ST_FAULT;
            end
            ST_HS_ON: begin
                if (fall) nx = ST_LS_WAIT;
            end
            ST_LS_WAIT: begin
                if (rise)           nx = ST_HS_WAIT;
                else if (sn.ug_low) nx = ST_LS_ON;
                else if (expired)   nx = ST_FAULT;
            end
            ST_LS_ON: begin
                if (rise)                    nx = ST_HS_WAIT;
                else if (!sn.fccm && sn.zc)  nx = ST_LS_HOLD;
            end
            ST_LS_HOLD: begin
                if (rise)      nx = ST_HS_WAIT;
                else if (fall) nx = ST_LS_WAIT;
            end
            default: nx = ST_IDLE;
        endcase
    end

    assign wcnt_nx = ((nx != st) || flag_ok) ? '0 : wcnt + CNT_W'(1);
    assign drv_nx  = drive_of(nx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            drv_q <= '0;
            pwm_d <= 1'b0;
            wcnt  <= '0;
        end else begin
            st    <= nx;
            drv_q <= drv_nx;
            pwm_d <= sn.pwm;
            wcnt  <= wcnt_nx;
        end
    end

    assign hs_en   = drv_q.hs;
    assign ls_en   = drv_q.ls;
    assign fault   = drv_q.flt;
    assign hs_drop = drv_q.hs & ~drv_nx.hs;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en))
        else $error("both gate enables high"); // R1
    AST_FAULT_SAFE: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!hs_en && !ls_en))
        else $error("gate enabled during fault"); // R10

endmodule

// File: rtl/adt_gate_ctrl.sv
module adt_gate_ctrl
    import adt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             fccm_in,
    input  logic             zc_in,
    input  logic             lg_low_in,
    input  logic             ug_low_in,
    input  logic [CNT_W-1:0] min_off_cyc,
    input  logic [CNT_W-1:0] sense_timeout,
    output logic             hs_en,
    output logic             ls_en,
    output logic             oc_sample,
    output logic             fault
);

    localparam int LAT = SYNC_STAGES + 1;

    sense_t             raw, sn;
    logic [SENSE_W-1:0] sync_q;
    logic               moff_busy;
    logic               hs_drop;

    always_comb begin
        raw        = '0;
        raw.pwm    = pwm_in;
        raw.fccm   = fccm_in;
        raw.zc     = zc_in;
        raw.lg_low = lg_low_in;
        raw.ug_low = ug_low_in;
    end

    adt_sync #(
        .W      (SENSE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (sync_q)
    );

    assign sn = sense_t'(sync_q);

    adt_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sn        (sn),
        .moff_busy (moff_busy),
        .timeout   (sense_timeout),
        .hs_en     (hs_en),
        .ls_en     (ls_en),
        .fault     (fault),
        .hs_drop   (hs_drop)
    );

    adt_offtimer #(
        .CNT_W (CNT_W)
    ) u_off (
        .clk       (clk),
        .rst       (rst),
        .hs_drop   (hs_drop),
        .hs_en     (hs_en),
        .min_off   (min_off_cyc),
        .busy      (moff_busy),
        .oc_sample (oc_sample)
    );

    AST_HS_NEEDS_LG: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> $past(lg_low_in, LAT))
        else $error("high side on without low gate flag"); // R3
    AST_LS_NEEDS_UG: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> $past(ug_low_in, LAT))
        else $error("low side on without high gate flag"); // R4
    AST_ZC_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        ($past(ls_en) && $past(zc_in, LAT) && !$past(fccm_in, LAT)) |-> !ls_en)
        else $error("low side not cut at zero cross"); // R5
    AST_FCCM_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(ls_en) && $past(fccm_in, LAT) && !$past(pwm_in, LAT)) |-> ls_en)
        else $error("low side dropped in continuous mode"); // R7

endmodule

// File: tb/sim_adt_gate_ctrl.sv
module sim_adt_gate_ctrl;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwm = 1'b0, fccm = 1'b0, zc = 1'b0, lg = 1'b1, ug = 1'b1;
    logic [CW-1:0] moff = 8'd4, tmo = 8'd20;
    logic          hs_en, ls_en, oc_sample, fault;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    adt_gate_ctrl #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .pwm_in(pwm), .fccm_in(fccm), .zc_in(zc),
        .lg_low_in(lg), .ug_low_in(ug), .min_off_cyc(moff),
        .sense_timeout(tmo), .hs_en(hs_en), .ls_en(ls_en),
        .oc_sample(oc_sample), .fault(fault)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp_min);
        n_cmp++;
        if (act < exp_min) begin
            n_bad++;
            $display("FAIL %s: got %0d expected >= %0d at %0t", req, act, exp_min, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Expected-value functions for the random monitor (3 = sync latency view)
    function automatic logic exp_ls_after_zc(input logic prev_ls, input logic zc3, input logic fccm3);
        return !(prev_ls && zc3 && !fccm3);
    endfunction
    function automatic logic keeps_ls(input logic prev_ls, input logic fccm3, input logic pwm3);
        return prev_ls && fccm3 && !pwm3;
    endfunction
    function automatic int oc_expected(input logic [CW-1:0] m);
        return (m >= 1) ? 1 : 0;
    endfunction

    // Input history, index 0 = value taken at the latest edge
    logic [3:0] h_pwm = '0;
    logic [2:0] h_fccm = '0, h_zc = '0, h_lg = '0, h_ug = '0;
    always @(posedge clk) begin
        h_pwm  <= {h_pwm[2:0], pwm};
        h_fccm <= {h_fccm[1:0], fccm};
        h_zc   <= {h_zc[1:0], zc};
        h_lg   <= {h_lg[1:0], lg};
        h_ug   <= {h_ug[1:0], ug};
    end

    logic mon_on = 1'b0;
    logic p_hs = 1'b0, p_ls = 1'b0, hold = 1'b0, seen_drop = 1'b0;
    int   run = 0, ocn = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            chk("R1 no overlap", hs_en && ls_en, 1'b0);
            if (hold) chk("R6 low side held after zero cross", ls_en, 1'b0);
            if (p_ls && h_zc[2] && !h_fccm[2])
                chk("R5 zero-cross cut", ls_en, exp_ls_after_zc(p_ls, h_zc[2], h_fccm[2]));
            if (keeps_ls(p_ls, h_fccm[2], h_pwm[2]))
                chk("R7 continuous mode keeps low side", ls_en, 1'b1);
            if (ls_en && !p_ls) chk("R4 low side needs flag", h_ug[2], 1'b1);
            if (hs_en && !p_hs) begin
                chk("R3 high side needs flag", h_lg[2], 1'b1);
                if (seen_drop) begin
                    chk_int("R8 minimum off length", run, int'(moff));
                    n_cmp++;
                    if (ocn != oc_expected(moff)) begin
                        n_bad++;
                        $display("FAIL R9 strobe count: got %0d expected %0d", ocn, oc_expected(moff));
                    end
                end
            end
            if (!h_pwm[2] && h_pwm[3]) hold = 1'b0;
            else if (p_ls && !ls_en && !h_pwm[2]) hold = 1'b1;
            if (!hs_en && p_hs) begin
                run = 1; ocn = 0; seen_drop = 1'b1;
            end else if (!hs_en) begin
                run++;
            end
            if (oc_sample) begin
                ocn++;
                chk("R9 strobe while high side off", hs_en, 1'b0);
            end
        end
        p_hs = hs_en;
        p_ls = ls_en;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd5150));
        step(3);
        chk("R2 reset hs", hs_en, 1'b0);
        chk("R2 reset ls", ls_en, 1'b0);
        chk("R2 reset fault", fault, 1'b0);
        rst = 1'b0;
        step(12);
        chk("R2 wait first edge hs", hs_en, 1'b0);
        chk("R2 wait first edge ls", ls_en, 1'b0);
        chk("R2 no strobe", oc_sample, 1'b0);

        // R3 latency
        pwm = 1'b1;
        step(3); chk("R3 hs not yet", hs_en, 1'b0);
        step(1); chk("R3 hs on 4th edge", hs_en, 1'b1);

        // R4 late flag
        ug = 1'b0; pwm = 1'b0;
        step(3); chk("R4 hs off", hs_en, 1'b0);
        step(5); chk("R4 ls waits for flag", ls_en, 1'b0);
        ug = 1'b1;
        step(2); chk("R4 ls not yet", ls_en, 1'b0);
        step(1); chk("R4 ls on 3rd edge after flag", ls_en, 1'b1);

        // R7 continuous mode ignores zero cross
        fccm = 1'b1; zc = 1'b1;
        step(10); chk("R7 ls held", ls_en, 1'b1);
        fccm = 1'b0; zc = 1'b0;
        step(4); chk("R7 ls still on", ls_en, 1'b1);

        // R5 / R6 diode emulation
        zc = 1'b1;
        step(2); chk("R5 ls before cut", ls_en, 1'b1);
        step(1); chk("R5 ls cut on 3rd edge", ls_en, 1'b0);
        zc = 1'b0;
        step(10); chk("R6 ls stays off", ls_en, 1'b0);

        // R8 / R9 minimum off and strobe placement
        moff = 8'd8;
        pwm = 1'b1;
        step(4); chk("R6 rise leaves hold, hs on", hs_en, 1'b1);
        pwm = 1'b0;
        step(3); chk("R8 hs off", hs_en, 1'b0);
        pwm = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            step(1);
            chk("R9 strobe position", oc_sample, (k == 7));
            chk("R8 deferred turn-on", hs_en, (k == 8));
        end

        // R10 timeout fault
        tmo = 8'd5; lg = 1'b0;
        pwm = 1'b0;
        step(6); chk("R10 ls on before test", ls_en, 1'b1);
        pwm = 1'b1;
        step(8); chk("R10 no fault yet", fault, 1'b0);
        step(1); chk("R10 fault raised", fault, 1'b1);
        chk("R10 hs off in fault", hs_en, 1'b0);
        chk("R10 ls off in fault", ls_en, 1'b0);
        lg = 1'b1;
        step(5); chk("R10 late flag ignored", hs_en, 1'b0);
        chk("R10 fault held", fault, 1'b1);
        pwm = 1'b0;
        step(3); chk("R10 edge clears fault", fault, 1'b0);
        step(1); chk("R10 restart ls", ls_en, 1'b1);

        // R11 cancel pending high-side turn-on
        tmo = 8'd20; lg = 1'b0;
        pwm = 1'b1;
        for (int k = 0; k < 6; k++) begin
            step(1);
            chk("R11 hs stays off", hs_en, 1'b0);
        end
        pwm = 1'b0;
        step(3); chk("R11 hs never on", hs_en, 1'b0);
        step(1); chk("R11 ls wait taken", ls_en, 1'b1);
        chk("R11 no fault", fault, 1'b0);
        lg = 1'b1;
        step(5);

        // Random phase
        moff = CW'(1 + $urandom % 8);
        tmo  = 8'd40;
        cnt  = 0;
        mon_on = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (cnt == 0) begin
                pwm = ~pwm;
                cnt = 6 + $urandom % 30;
            end else begin
                cnt--;
            end
            lg = !ls_en && ($urandom % 6 != 0);
            ug = !hs_en && ($urandom % 6 != 0);
            zc = !pwm && ($urandom % 12 == 0);
            if ($urandom % 200 == 0) fccm = ~fccm;
            step(1);
        end
        mon_on = 1'b0;
        step(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule